// File: doc/BRIEF.md
# Sigma-Delta Decimator with Byte Packer

This block turns two 1-bit sigma-delta bitstreams (left and right), each delivering one bit per clock at 128 times the audio sample rate, into audio samples at the base rate. Each channel goes through a fourth-order cascaded integrator-comb decimator. The result is cut down to an 8, 16 or 24-bit word, and the words are serialised as bytes on a valid/ready stream for a byte-oriented transport.

Software picks the word width, mono or stereo operation, and whether each channel is powered. A powered-down channel keeps its filter state at zero and sends zero-valued words, so the stereo byte layout does not change. The sink may stall. When a new sample arrives before the previous one has fully left, the new sample is dropped and a sticky overflow flag is raised. Only a clear pulse lowers the flag.

Top module: `sd_decim_packer`

## Requirements
- R1: Exactly one sample is produced every 128 clocks. After reset, consecutive byte groups start 128 clocks apart.
- R2: A bit value of 1 adds to the level and 0 subtracts from it. For a settled input whose fraction of ones is d, the sample is d·2^28 − 2^27 on a 28-bit two's-complement scale. The all-ones case saturates to 2^27−1, so all ones gives the largest positive word, all zeros the most negative word, and alternating bits give zero.
- R3: `width_sel` code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 24 bits. Each channel word is sent as 1, 2 or 3 bytes to match.
- R4: The output word is the top 8, 16 or 24 bits of the 28-bit sample (truncation, which rounds toward negative infinity).
- R5: Within a channel word, bytes go least significant first. In stereo, all left bytes come before the right bytes of the same sample.
- R6: When `stereo` is 0, only the left channel's bytes are sent for each sample.
- R7: A channel whose enable is 0 has its integrator and comb state cleared to zero. Its word is sent as all-zero bytes.
- R8: While `byte_valid` is high and `byte_ready` is low, `byte_valid` stays high and `byte_data` does not change.
- R9: A new sample that arrives while bytes of the previous one are still unsent is dropped, and `overflow` is set. `overflow` stays high until `ovf_clear` is pulsed.
- R10: During and after reset, `byte_valid` and `overflow` are low until the first sample is formed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one bitstream bit per edge |
| rst | input | 1 | Synchronous active-high reset |
| sd_left | input | 1 | Left sigma-delta bit |
| sd_right | input | 1 | Right sigma-delta bit |
| en_left | input | 1 | Left channel power enable |
| en_right | input | 1 | Right channel power enable |
| stereo | input | 1 | 1 = send both channels, 0 = left only |
| width_sel | input | 2 | Output width code (0: 8, 1: 16, 2/3: 24 bits) |
| byte_data | output | 8 | Output byte |
| byte_valid | output | 1 | Output byte is valid |
| byte_ready | input | 1 | Sink accepts the byte |
| ovf_clear | input | 1 | Clears the overflow flag |
| overflow | output | 1 | Sticky flag: a sample was dropped |

## Verification
The bench drives periodic bitstreams whose densities (0, 1/4, 1/2, 3/4, 1) make the settled filter output exact. A wrong scaling, offset or saturation therefore shows up as a wrong word value; a missing top-end clamp, for example, wraps all-ones input to the most negative code. Each width code, including the alias code 3, is checked for byte count and byte order. A packer that swaps byte order, leaks the right channel in mono, or miscounts bytes produces a frame of the wrong length or a permuted value. Channel disable is tested in both positions: a design that keeps integrating or forgets to zero the word sends a non-zero channel. A long stall exercises the hold-and-drop path: a design that overwrote the pending frame, changed data under stall, or let the flag clear itself fails there.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    localparam int CIC_ORDER = 4;
    localparam int DEC_LOG2  = 7;
    localparam int DEC_RATIO = 1 << DEC_LOG2;
    localparam int ACC_W     = 1 + CIC_ORDER * DEC_LOG2;
    localparam int SAMP_W    = ACC_W - 1;
    localparam int WORD_W    = 24;
    localparam int NCHAN     = 2;

    typedef enum logic [1:0] {
        WID_8   = 2'd0,
        WID_16  = 2'd1,
        WID_24  = 2'd2,
        WID_24B = 2'd3
    } width_e;

    typedef struct packed {
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
        logic [1:0]        nbytes;
        logic              stereo;
    } frame_t;

    localparam logic signed [ACC_W-1:0] SAMP_OFS = ACC_W'(1) <<< (SAMP_W - 1);
    localparam logic signed [ACC_W-1:0] SAMP_MAX = SAMP_OFS - ACC_W'(1);

    // Remove the unipolar offset and clamp the single top-end code.
    function automatic logic [SAMP_W-1:0] to_sample(input logic [ACC_W-1:0] acc);
        logic signed [ACC_W-1:0] s;
        s = $signed(acc) - SAMP_OFS;
        if (s > SAMP_MAX) s = SAMP_MAX;
        return s[SAMP_W-1:0];
    endfunction

    // Keep the most significant bits, right-justified in the word.
    function automatic logic [WORD_W-1:0] to_word(input logic [SAMP_W-1:0] smp,
                                                  input width_e w);
        case (w)
            WID_8:   return {16'h0000, smp[SAMP_W-1 -: 8]};
            WID_16:  return {8'h00,    smp[SAMP_W-1 -: 16]};
            default: return smp[SAMP_W-1 -: 24];
        endcase
    endfunction

    function automatic logic [1:0] byte_count(input width_e w);
        case (w)
            WID_8:   return 2'd1;
            WID_16:  return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/sdp_cic.sv
module sdp_cic
    import sdp_pkg::*;
#(
    parameter int ORDER = CIC_ORDER,
    parameter int AW    = ACC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          bit_in,
    input  logic          tick,
    output logic [AW-1:0] sum_o,
    output logic          sum_vld
);

    logic [ORDER-1:0][AW-1:0] integ;
    logic [ORDER-1:0][AW-1:0] dly;
    logic [ORDER:0][AW-1:0]   diff;

    // Integrators run at the bit rate and wrap modulo 2^AW.
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            integ <= '0;
        end else begin
            integ[0] <= integ[0] + {{(AW-1){1'b0}}, bit_in};
            for (int k = 1; k < ORDER; k++) begin
                integ[k] <= integ[k] + integ[k-1];
            end
        end
    end

    // Comb differences evaluated on the decimation strobe only.
    always_comb begin
        diff[0] = integ[ORDER-1];
        for (int k = 0; k < ORDER; k++) begin
            diff[k+1] = diff[k] - dly[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dly     <= '0;
            sum_o   <= '0;
            sum_vld <= 1'b0;
        end else begin
            sum_vld <= tick;
            if (!en) begin
                dly   <= '0;
                sum_o <= '0;
            end else if (tick) begin
                for (int k = 0; k < ORDER; k++) begin
                    dly[k] <= diff[k];
                end
                sum_o <= diff[ORDER];
            end
        end
    end

    // R7: a powered-down channel keeps its filter state at zero
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (integ == '0) && (dly == '0));

endmodule

// File: rtl/sdp_format.sv
module sdp_format
    import sdp_pkg::*;
#(
    parameter int AW = ACC_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sum_vld,
    input  logic [NCHAN-1:0][AW-1:0]  sums,
    input  logic [NCHAN-1:0]          chan_en,
    input  logic [1:0]                width_sel,
    input  logic                      stereo,
    output frame_t                    frame_o,
    output logic                      frame_vld
);

    width_e wsel;
    assign wsel = width_e'(width_sel);

    logic [NCHAN-1:0][WORD_W-1:0] words;

    generate
        for (genvar c = 0; c < NCHAN; c++) begin : g_word
            assign words[c] = chan_en[c] ? to_word(to_sample(sums[c]), wsel)
                                         : '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_o   <= '0;
            frame_vld <= 1'b0;
        end else begin
            frame_vld <= sum_vld;
            if (sum_vld) begin
                frame_o.left   <= words[0];
                frame_o.right  <= words[1];
                frame_o.nbytes <= byte_count(wsel);
                frame_o.stereo <= stereo;
            end
        end
    end

    // R4: a narrow word leaves the unused upper bytes clear
    p_narrow_clear_r4: assert property (@(posedge clk) disable iff (rst)
        frame_vld && frame_o.nbytes == 2'd1 |->
            frame_o.left[WORD_W-1:8] == '0 && frame_o.right[WORD_W-1:8] == '0);

endmodule

// File: rtl/sdp_packer.sv
module sdp_packer
    import sdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_t     frm_i,
    input  logic       frm_vld,
    input  logic       byte_ready,
    input  logic       ovf_clear,
    output logic [7:0] byte_data,
    output logic       byte_valid,
    output logic       overflow
);

    frame_t            cur;
    logic              busy;
    logic              chan;
    logic [1:0]        idx;
    logic [WORD_W-1:0] word;
    logic              chan_end;
    logic              last;
    logic              take;

    assign chan_end = (idx == cur.nbytes - 2'd1);
    assign last     = chan_end && (chan || !cur.stereo);
    assign take     = busy && byte_ready;

    always_comb begin
        word = chan ? cur.right : cur.left;
        case (idx)
            2'd0:    byte_data = word[7:0];
            2'd1:    byte_data = word[15:8];
            default: byte_data = word[23:16];
        endcase
    end

    assign byte_valid = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            busy     <= 1'b0;
            chan     <= 1'b0;
            idx      <= 2'd0;
            overflow <= 1'b0;
        end else begin
            if (frm_vld && (!busy || (take && last))) begin
                cur  <= frm_i;
                busy <= 1'b1;
                chan <= 1'b0;
                idx  <= 2'd0;
            end else if (take) begin
                if (last) begin
                    busy <= 1'b0;
                end else if (chan_end) begin
                    chan <= 1'b1;
                    idx  <= 2'd0;
                end else begin
                    idx <= idx + 2'd1;
                end
            end

            if (frm_vld && busy && !(take && last)) begin
                overflow <= 1'b1;
            end else if (ovf_clear) begin
                overflow <= 1'b0;
            end
        end
    end

    // R8: a stalled byte is held unchanged
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        byte_valid && !byte_ready |=> byte_valid && $stable(byte_data));

    // R9: a dropped sample raises the flag
    p_drop_flag_r9: assert property (@(posedge clk) disable iff (rst)
        frm_vld && busy && !byte_ready |=> overflow);

    // R9: the flag only falls on a clear request
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(overflow) |-> $past(ovf_clear));

    // R6: mono frames never reach the right channel
    p_mono_left_r6: assert property (@(posedge clk) disable iff (rst)
        byte_valid && !cur.stereo |-> !chan);

    // R3: the byte index stays within the selected width
    p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> idx < cur.nbytes);

endmodule

// File: rtl/sd_decim_packer.sv
module sd_decim_packer
    import sdp_pkg::*;
#(
    parameter int ORDER = CIC_ORDER,
    parameter int RLOG2 = DEC_LOG2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sd_left,
    input  logic       sd_right,
    input  logic       en_left,
    input  logic       en_right,
    input  logic       stereo,
    input  logic [1:0] width_sel,
    output logic [7:0] byte_data,
    output logic       byte_valid,
    input  logic       byte_ready,
    input  logic       ovf_clear,
    output logic       overflow
);

    localparam int AW    = 1 + ORDER * RLOG2;
    localparam int RATIO = 1 << RLOG2;

    logic [RLOG2-1:0]           phase;
    logic                       tick;
    logic [NCHAN-1:0]           sd_bits;
    logic [NCHAN-1:0]           chan_en;
    logic [NCHAN-1:0][AW-1:0]   sums;
    logic [NCHAN-1:0]           sums_vld;
    frame_t                     frame;
    logic                       frame_vld;

    assign sd_bits = {sd_right, sd_left};
    assign chan_en = {en_right, en_left};

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
    end

    assign tick = &phase;

    generate
        for (genvar c = 0; c < NCHAN; c++) begin : g_chan
            sdp_cic #(.ORDER(ORDER), .AW(AW)) i_cic (
                .clk     (clk),
                .rst     (rst),
                .en      (chan_en[c]),
                .bit_in  (sd_bits[c]),
                .tick    (tick),
                .sum_o   (sums[c]),
                .sum_vld (sums_vld[c])
            );
        end
    endgenerate

    sdp_format #(.AW(AW)) i_format (
        .clk       (clk),
        .rst       (rst),
        .sum_vld   (sums_vld[0]),
        .sums      (sums),
        .chan_en   (chan_en),
        .width_sel (width_sel),
        .stereo    (stereo),
        .frame_o   (frame),
        .frame_vld (frame_vld)
    );

    sdp_packer i_packer (
        .clk        (clk),
        .rst        (rst),
        .frm_i      (frame),
        .frm_vld    (frame_vld),
        .byte_ready (byte_ready),
        .ovf_clear  (ovf_clear),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .overflow   (overflow)
    );

    // Independent interval counter for the decimation strobe.
    logic [RLOG2:0] since;
    logic           seen;
    always_ff @(posedge clk) begin
        if (rst) begin
            since <= '0;
            seen  <= 1'b0;
        end else begin
            since <= tick ? '0 : since + 1'b1;
            if (tick) seen <= 1'b1;
        end
    end

    // R1: strobes are exactly one decimation ratio apart
    p_period_r1: assert property (@(posedge clk) disable iff (rst)
        tick && seen |-> since == (RLOG2+1)'(RATIO - 1));

    // R10: no bytes and no flag until a frame has been formed
    p_quiet_start_r10: assert property (@(posedge clk) disable iff (rst)
        !seen |-> !byte_valid && !overflow);

endmodule

// File: tb/test_sd_decim_packer.sv
`timescale 1ns/1ps
module test_sd_decim_packer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sd_left = 1'b0, sd_right = 1'b0;
    logic       en_left = 1'b1, en_right = 1'b1;
    logic       stereo = 1'b1;
    logic [1:0] width_sel = 2'd2;
    logic [7:0] byte_data;
    logic       byte_valid;
    logic       byte_ready = 1'b1;
    logic       ovf_clear = 1'b0;
    logic       overflow;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int lpat  = 0;
    int rpat  = 0;

    always #2.5 clk = ~clk;

    sd_decim_packer i_sd_decim_packer (
        .clk(clk), .rst(rst), .sd_left(sd_left), .sd_right(sd_right),
        .en_left(en_left), .en_right(en_right), .stereo(stereo),
        .width_sel(width_sel), .byte_data(byte_data), .byte_valid(byte_valid),
        .byte_ready(byte_ready), .ovf_clear(ovf_clear), .overflow(overflow)
    );

    // Pattern codes: 0 all zero, 1 all one, 2 alternating, 3 three of four ones, 4 one of four ones.
    function automatic logic pat_bit(input int p, input int n);
        case (p)
            0:       return 1'b0;
            1:       return 1'b1;
            2:       return n[0];
            3:       return (n % 4) != 0;
            default: return (n % 4) == 0;
        endcase
    endfunction

    always @(negedge clk) begin
        cyc      <= cyc + 1;
        sd_left  <= pat_bit(lpat, cyc);
        sd_right <= pat_bit(rpat, cyc);
    end

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Waits for an idle gap, then collects one burst of bytes.
    task automatic grab_frame(output int n, output logic [47:0] got, output int t0);
        int quiet;
        quiet = 0;
        while (quiet < 12) begin
            @(negedge clk);
            if (byte_valid) quiet = 0; else quiet++;
        end
        n = 0; got = '0; t0 = 0; quiet = 0;
        while (quiet < 12) begin
            @(negedge clk);
            if (byte_valid && byte_ready) begin
                if (n == 0) t0 = cyc;
                if (n < 6) got = got | (48'(byte_data) << (8 * n));
                n++;
                quiet = 0;
            end else if (n > 0) begin
                quiet++;
            end
        end
    endtask

    // Fields: lpat, rpat, width code, stereo, en_left, en_right, expected left word, expected right word.
    localparam int NV = 9;
    localparam logic [58:0] VEC [NV] = '{
        {3'd1, 3'd0, 2'd2, 1'b1, 1'b1, 1'b1, 24'h7FFFFF, 24'h800000},
        {3'd3, 3'd4, 2'd1, 1'b1, 1'b1, 1'b1, 24'h004000, 24'h00C000},
        {3'd2, 3'd1, 2'd0, 1'b1, 1'b1, 1'b1, 24'h000000, 24'h00007F},
        {3'd4, 3'd3, 2'd2, 1'b0, 1'b1, 1'b1, 24'hC00000, 24'h000000},
        {3'd0, 3'd2, 2'd0, 1'b0, 1'b1, 1'b1, 24'h000080, 24'h000000},
        {3'd1, 3'd3, 2'd2, 1'b1, 1'b1, 1'b0, 24'h7FFFFF, 24'h000000},
        {3'd3, 3'd1, 2'd1, 1'b1, 1'b0, 1'b1, 24'h000000, 24'h007FFF},
        {3'd4, 3'd0, 2'd3, 1'b1, 1'b1, 1'b1, 24'hC00000, 24'h800000},
        {3'd0, 3'd1, 2'd1, 1'b0, 1'b1, 1'b1, 24'h008000, 24'h000000}
    };

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R1 act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, t0, t1, nb, wbits;
        logic [47:0] got, exp;
        logic [7:0]  held;
        logic [58:0] v;

        // R10: reset state
        repeat (5) @(negedge clk);
        check("R10 valid in reset", byte_valid, 0);
        check("R10 overflow in reset", overflow, 0);
        rst = 1'b0;
        repeat (100) @(negedge clk);
        check("R10 valid before first sample", byte_valid, 0);
        check("R10 overflow before first sample", overflow, 0);

        // R2 R3 R4 R5 R6 R7: table of patterns and modes
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            lpat      = int'(v[58:56]);
            rpat      = int'(v[55:53]);
            width_sel = v[52:51];
            stereo    = v[50];
            en_left   = v[49];
            en_right  = v[48];
            repeat (800) @(negedge clk);
            grab_frame(n, got, t0);
            nb    = (v[52:51] == 2'd0) ? 1 : (v[52:51] == 2'd1) ? 2 : 3;
            wbits = 8 * nb;
            exp   = 48'(v[47:24]);
            if (v[50]) exp = exp | (48'(v[23:0]) << wbits);
            check($sformatf("R3 R6 byte count vec%0d", i), n, nb * (v[50] ? 2 : 1));
            check($sformatf("R2 R4 R5 R7 frame value vec%0d", i), got, exp);
        end

        // R1: spacing of consecutive frames
        lpat = 2; rpat = 2; width_sel = 2'd0; stereo = 1'b1;
        en_left = 1'b1; en_right = 1'b1;
        grab_frame(n, got, t0);
        grab_frame(n, got, t1);
        check("R1 frame spacing", t1 - t0, 128);

        // R8 R9: stall, hold and drop
        width_sel = 2'd2;
        repeat (200) @(negedge clk);
        byte_ready = 1'b0;
        repeat (150) @(negedge clk);
        check("R8 valid under stall", byte_valid, 1);
        held = byte_data;
        repeat (150) @(negedge clk);
        check("R8 data held under stall", byte_data, held);
        check("R9 overflow set on drop", overflow, 1);
        byte_ready = 1'b1;
        repeat (40) @(negedge clk);
        check("R9 overflow sticky after drain", overflow, 1);
        ovf_clear = 1'b1;
        @(negedge clk);
        ovf_clear = 1'b0;
        @(negedge clk);
        check("R9 overflow cleared", overflow, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule